// File: doc/BRIEF.md
# Line Transfer and Precharge Sequencer

This block sits between the line input register of a column driver and its output stage. Two active-low strobes, `tp1_ni` and `tp2_ni`, are held high while a line is being collected. When the host drops `tp1_ni` with `tp2_ni` still high, the next rising clock edge copies the whole input register into a storage register. It also pulses a one-cycle load strobe toward the converters, so the input register is free to take the next line. The block captures only once per low period of `tp1_ni`, however many clock edges that period spans.

The output stage is gated from the strobe levels themselves, without waiting for a clock. While either strobe is low, precharge is asserted and the converter-to-output path is disabled. The legal order has four steps. First `tp1_ni` falls. Then `tp2_ni` falls. Then `tp1_ni` rises. Last, `tp2_ni` rises, which ends precharge.

A small clocked phase tracker watches this order. After reset the outputs stay in precharge until one unbroken legal sequence has been seen. The tracker also raises a sticky error flag on any sampled strobe change that skips a step, runs backwards, or moves both strobes in the same sample. Microsecond-scale spacing between strobe edges is left to the host.

Top module: `line_xfer_seq`

## Requirements
- R1: While reset (`rst_ni` low) is applied and directly after it, `out_en_o` is 0, `precharge_o` is 1, `order_err_o` is 0, `conv_load_o` is 0 and `store_o` is all zeros.
- R2: At the first rising clock edge at which `tp1_ni` is sampled low, if `tp2_ni` is sampled high at that edge, `store_o` takes the `line_i` value sampled at that edge. `conv_load_o` is 1 for exactly the following clock cycle.
- R3: Later clock edges in the same `tp1_ni` low period cause no further capture. Changes on `line_i` during that period leave `store_o` unchanged and `conv_load_o` low.
- R4: If `tp2_ni` is low at the first edge of a `tp1_ni` low period, no capture happens in that period, even if `tp2_ni` rises before `tp1_ni` does.
- R5: Whenever `tp1_ni` or `tp2_ni` is low, `precharge_o` is 1 and `out_en_o` is 0 at once, without waiting for a clock edge.
- R6: After reset, `out_en_o` stays 0 until an unbroken legal sequence has been sampled. That sequence starts with a clocked `tp1_ni` fall from the both-high state. It becomes 1 from the first rising edge at which both strobes are sampled high after the step with `tp1_ni` high and `tp2_ni` low. A sequence that contains an illegal step does not enable the outputs.
- R7: Once enabled, `out_en_o` equals `tp1_ni` AND `tp2_ni` and `precharge_o` is its complement, combinationally.
- R8: The sampled strobe pair is read as a phase: both high = 0, only `tp1_ni` low = 1, both low = 2, only `tp2_ni` low = 3. Staying in a phase is legal, and so is moving from phase k to phase (k+1) mod 4. Any other change sets `order_err_o` from the next cycle, and it stays 1 until reset.
- R9: Strobe sequences that follow the legal order, with any number of clock edges spent in each phase, never set `order_err_o`.
- R10: Between captures `store_o` holds its value, whatever `line_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tp1_ni | input | 1 | First transfer strobe, active low |
| tp2_ni | input | 1 | Second transfer strobe, active low |
| line_i | input | NCH*BITS (1440) | Input register contents, channel c in bits [c*BITS +: BITS] |
| store_o | output | NCH*BITS (1440) | Storage register contents, same layout |
| precharge_o | output | 1 | High while the output stage precharges |
| out_en_o | output | 1 | High while converters drive the outputs |
| conv_load_o | output | 1 | One-cycle pulse after each storage capture |
| order_err_o | output | 1 | Sticky flag for an illegal strobe ordering |

## Verification
The capture path is driven with a fresh channel pattern on every line. The bench then changes `line_i` during the strobe-low period and the acquisition that follows. This tells a single, correctly timed capture apart from repeated captures or a storage register that follows its input. The bench tries full legal sequences, with extra dwell edges in some phases, against three kinds of broken order: a second strobe falling first, both strobes moving in one sample, and a backward step. This separates the sticky error and the arming rule from plain level gating. Gating is checked between clock edges, right after each strobe change, both before and after arming. That shows the output enable follows the strobes combinationally only once a legal sequence has completed.

// File: rtl/line_xfer_pkg.sv
package line_xfer_pkg;

    typedef enum logic [1:0] {
        PH_ACQ     = 2'd0,
        PH_LATCH   = 2'd1,
        PH_CONVERT = 2'd2,
        PH_SETTLE  = 2'd3
    } phase_e;

    function automatic phase_e phase_of(input logic s1_n, input logic s2_n);
        case ({s1_n, s2_n})
            2'b11:   return PH_ACQ;
            2'b01:   return PH_LATCH;
            2'b00:   return PH_CONVERT;
            default: return PH_SETTLE;
        endcase
    endfunction

endpackage

// File: rtl/lx_phase_fsm.sv
module lx_phase_fsm
    import line_xfer_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tp1_ni,
    input  logic tp2_ni,
    output logic armed_o,
    output logic err_o
);

    typedef struct packed {
        phase_e phase;
        logic   seq_ok;
        logic   armed;
        logic   err;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    phase_e lvl;
    logic   legal;

    always_comb begin
        lvl   = phase_of(tp1_ni, tp2_ni);
        legal = (lvl == fsm_q.phase) || (lvl == phase_e'(fsm_q.phase + 2'd1));
        fsm_d = fsm_q;
        fsm_d.phase = lvl;
        if (!legal) begin
            fsm_d.err    = 1'b1;
            fsm_d.seq_ok = 1'b0;
        end else if (fsm_q.phase == PH_ACQ && lvl == PH_LATCH) begin
            fsm_d.seq_ok = 1'b1;
        end
        if (legal && fsm_q.seq_ok && fsm_q.phase == PH_SETTLE && lvl == PH_ACQ) begin
            fsm_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{phase: PH_ACQ, seq_ok: 1'b0, armed: 1'b0, err: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign armed_o = fsm_q.armed;
    assign err_o   = fsm_q.err;

    // R8: once raised, the error flag never drops without reset
    assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsm_q.err |=> fsm_q.err);

    // R6: arming only follows the last phase of the sequence
    assert_arm_after_settle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fsm_q.armed) |-> ($past(fsm_q.phase) == PH_SETTLE));

endmodule

// File: rtl/lx_line_store.sv
module lx_line_store #(
    parameter int NCH  = 240,
    parameter int BITS = 6,
    localparam int W   = NCH * BITS
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tp1_ni,
    input  logic         tp2_ni,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] store_o,
    output logic         load_o
);

    typedef struct packed {
        logic seen_low;
        logic load;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic capture;

    always_comb begin
        capture        = !tp1_ni && tp2_ni && !ctl_q.seen_low;
        ctl_d          = ctl_q;
        ctl_d.seen_low = !tp1_ni;
        ctl_d.load     = capture;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [BITS-1:0] word_d, word_q;

        always_comb begin
            word_d = capture ? line_i[ch*BITS +: BITS] : word_q;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign store_o[ch*BITS +: BITS] = word_q;
    end

    assign load_o = ctl_q.load;

    // R2: a load pulse only follows an edge with TP1 low and TP2 high
    assert_load_cond_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q.load |-> ($past(tp1_ni) == 1'b0 && $past(tp2_ni) == 1'b1));

    // R3: the load pulse lasts one cycle
    assert_load_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q.load |=> !ctl_q.load);

    // R10: storage only moves together with a load pulse
    assert_store_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctl_q.load |-> $stable(store_o));

endmodule

// File: rtl/lx_out_gate.sv
module lx_out_gate (
    input  logic armed_i,
    input  logic tp1_ni,
    input  logic tp2_ni,
    output logic precharge_o,
    output logic out_en_o
);

    logic drive;

    always_comb begin
        drive       = armed_i && tp1_ni && tp2_ni;
        out_en_o    = drive;
        precharge_o = !drive;
    end

endmodule

// File: rtl/line_xfer_seq.sv
module line_xfer_seq #(
    parameter int NCH  = 240,
    parameter int BITS = 6,
    localparam int W   = NCH * BITS
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tp1_ni,
    input  logic         tp2_ni,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] store_o,
    output logic         precharge_o,
    output logic         out_en_o,
    output logic         conv_load_o,
    output logic         order_err_o
);

    logic armed;

    lx_phase_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tp1_ni  (tp1_ni),
        .tp2_ni  (tp2_ni),
        .armed_o (armed),
        .err_o   (order_err_o)
    );

    lx_line_store #(.NCH(NCH), .BITS(BITS)) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tp1_ni  (tp1_ni),
        .tp2_ni  (tp2_ni),
        .line_i  (line_i),
        .store_o (store_o),
        .load_o  (conv_load_o)
    );

    lx_out_gate u_gate (
        .armed_i     (armed),
        .tp1_ni      (tp1_ni),
        .tp2_ni      (tp2_ni),
        .precharge_o (precharge_o),
        .out_en_o    (out_en_o)
    );

endmodule

// File: tb/line_xfer_seq_tb.sv
module line_xfer_seq_tb;

    localparam int NCH  = 240;
    localparam int BITS = 6;
    localparam int W    = NCH * BITS;

    logic         clk = 1'b0;
    logic         rst_ni = 1'b0;
    logic         tp1_ni = 1'b1;
    logic         tp2_ni = 1'b1;
    logic [W-1:0] line_i = '0;
    logic [W-1:0] store_o;
    logic         precharge_o, out_en_o, conv_load_o, order_err_o;

    int nchk  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    line_xfer_seq #(.NCH(NCH), .BITS(BITS)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .tp1_ni(tp1_ni), .tp2_ni(tp2_ni),
        .line_i(line_i), .store_o(store_o), .precharge_o(precharge_o),
        .out_en_o(out_en_o), .conv_load_o(conv_load_o), .order_err_o(order_err_o)
    );

    function automatic logic [W-1:0] pat(input int s);
        logic [W-1:0] r;
        for (int c = 0; c < NCH; c++) r[c*BITS +: BITS] = BITS'((s * 13 + c * 5 + 1) % 64);
        return r;
    endfunction

    task automatic chk1(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chkv(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one rising edge, then back to the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0; tp1_ni = 1'b1; tp2_ni = 1'b1;
        #1;
        chk1("R1 out_en in reset", out_en_o, 1'b0);
        chk1("R1 precharge in reset", precharge_o, 1'b1);
        chk1("R1 err in reset", order_err_o, 1'b0);
        chk1("R1 load in reset", conv_load_o, 1'b0);
        chkv("R1 store in reset", store_o, '0);
        tick();
        rst_ni = 1'b1;
        tick();
        chk1("R1 out_en after reset", out_en_o, 1'b0);
        chk1("R1 precharge after reset", precharge_o, 1'b1);
        chk1("R1 err after reset", order_err_o, 1'b0);
    endtask

    task automatic t_first_line();
        line_i = pat(1);
        tp1_ni = 1'b0;
        #1;
        chk1("R5 precharge on tp1 fall", precharge_o, 1'b1);
        chk1("R5 out_en on tp1 fall", out_en_o, 1'b0);
        tick();
        chk1("R2 load pulse", conv_load_o, 1'b1);
        chkv("R2 store captured", store_o, pat(1));
        line_i = pat(2);
        tick();
        chk1("R3 no second load", conv_load_o, 1'b0);
        chkv("R3 store kept", store_o, pat(1));
        tp2_ni = 1'b0;
        tick();
        tick();
        tp1_ni = 1'b1;
        #1;
        chk1("R5 precharge tp2 low", precharge_o, 1'b1);
        tick();
        tp2_ni = 1'b1;
        #1;
        chk1("R6 not yet enabled before edge", out_en_o, 1'b0);
        tick();
        chk1("R6 enabled after first sequence", out_en_o, 1'b1);
        chk1("R6 precharge off", precharge_o, 1'b0);
        chk1("R9 no error on legal sequence", order_err_o, 1'b0);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 6; i++) begin
            line_i = pat(10 + i);
            tick();
            chk1("R10 no load while acquiring", conv_load_o, 1'b0);
            chkv("R10 store held", store_o, pat(1));
        end
    endtask

    task automatic t_armed_line();
        line_i = pat(3);
        tp1_ni = 1'b0;
        #1;
        chk1("R7 out_en drops at once", out_en_o, 1'b0);
        chk1("R7 precharge rises at once", precharge_o, 1'b1);
        tick();
        chk1("R2 load second line", conv_load_o, 1'b1);
        chkv("R2 store second line", store_o, pat(3));
        line_i = pat(4);
        tp2_ni = 1'b0;
        tick();
        chk1("R3 no load on tp2 fall", conv_load_o, 1'b0);
        tp1_ni = 1'b1;
        tick();
        tick();
        tp2_ni = 1'b1;
        #1;
        chk1("R7 out_en rises at once", out_en_o, 1'b1);
        chk1("R7 precharge falls at once", precharge_o, 1'b0);
        tick();
        chkv("R10 store after sequence", store_o, pat(3));
        chk1("R9 still no error", order_err_o, 1'b0);
    endtask

    task automatic t_bad_first();
        tp2_ni = 1'b0;
        tick();
        chk1("R8 tp2 first flags error", order_err_o, 1'b1);
        tp2_ni = 1'b1;
        tick();
        chk1("R6 broken sequence does not enable", out_en_o, 1'b0);
        chk1("R6 broken sequence keeps precharge", precharge_o, 1'b1);
        line_i = pat(5);
        tp1_ni = 1'b0; tick();
        chk1("R2 load after error", conv_load_o, 1'b1);
        chkv("R2 store after error", store_o, pat(5));
        tp2_ni = 1'b0; tick();
        tp1_ni = 1'b1; tick();
        tp2_ni = 1'b1; tick();
        chk1("R6 clean sequence enables", out_en_o, 1'b1);
        chk1("R8 error sticky", order_err_o, 1'b1);
    endtask

    task automatic t_both_fall();
        line_i = pat(6);
        tp1_ni = 1'b0; tp2_ni = 1'b0;
        tick();
        chk1("R4 no load with tp2 low", conv_load_o, 1'b0);
        chkv("R4 store untouched", store_o, pat(5));
        tp2_ni = 1'b1;
        tick();
        chk1("R4 no late load", conv_load_o, 1'b0);
        tick();
        chkv("R4 store still untouched", store_o, pat(5));
        tp1_ni = 1'b1;
        tick();
        chk1("R8 error still set", order_err_o, 1'b1);
        chk1("R7 enabled with strobes high", out_en_o, 1'b1);
    endtask

    initial begin
        #(20000 * 8);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        do_reset();
        t_first_line();
        t_hold();
        t_armed_line();
        do_reset();
        t_bad_first();
        t_both_fall();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule